// File: doc/BRIEF.md
# Fixed and Programmable Interval Timer Pair

This block holds two interval timers that advance on a single-cycle time-base tick enable. The fixed timer watches a free-running tick counter and flags an event each time a power-of-two number of ticks has elapsed. The period is one of four lengths, picked by a two-bit field of the control word. The programmable timer counts down from a value that software loads. It can either stop after one expiry or reload itself and keep running.

Both timers share one 32-bit control word and one 32-bit status word. Expiry of a timer sets its status flag. Software clears a status flag by writing a one to that bit position. Each interrupt output is the timer's status flag gated by that timer's enable bit in the control word. The current count of the programmable timer is visible on an output port.

Top module: `ivt_pair`

## Requirements
- R1: After reset the control word, the status word and the programmable count are zero, and both interrupt outputs are low.
- R2: Control bits 25:24 select the fixed period. The values 0, 1, 2 and 3 select 2^FIT_EXP0, 2^FIT_EXP1, 2^FIT_EXP2 and 2^FIT_EXP3 ticks. By default these are 2^9, 2^13, 2^17 and 2^21. Counting from reset, status bit 26 sets on every tick whose number is a multiple of the selected period.
- R3: The fixed-timer interrupt output equals status bit 26 AND control bit 23.
- R4: A status clear write drops every status bit that has a one in the write data and leaves the other bits alone. A timer expiry in the same cycle as a clear of its bit leaves the bit set.
- R5: A write to the programmable timer loads both its reload value and its count. The timer runs only if the loaded value is greater than 1 and control bit 26 is set at the time of the write. Clearing control bit 26 stops a running timer, and its count then holds.
- R6: While it runs, the programmable count drops by one on each tick. It expires on the tick where the count is 1. Expiry sets status bit 27. The programmable interrupt output equals status bit 27 AND control bit 26.
- R7: If control bit 22 is set at expiry, the count reloads, so each later period lasts exactly the reload value in ticks. If bit 22 is clear, the count goes to 0 and the timer stops.
- R8: In a cycle with no tick and no load, the programmable count does not change.
- R9: A control write stores all 32 bits, which read back unchanged on the control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable, one cycle per tick |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_data_i | input | 32 | Ones mark the status bits to clear |
| pit_we_i | input | 1 | Programmable timer load strobe |
| pit_wdata_i | input | CNT_W | Programmable timer load value |
| ctl_o | output | 32 | Control word |
| sts_o | output | 32 | Status word (bit 26 fixed timer, bit 27 programmable timer) |
| pit_count_o | output | CNT_W | Programmable timer current count |
| fit_irq_o | output | 1 | Fixed timer interrupt |
| pit_irq_o | output | 1 | Programmable timer interrupt |

## Verification
The assertions assume the following:
- Every fixed-period exponent is at least 1, so two fixed expiries can never fall on consecutive ticks.
- Ticks arrive only as the tick enable, so a cycle without it must leave the programmable count unchanged.

The stimulus keeps within these limits. The bench sets the exponents to 3, 4, 5 and 6. It drives every write and every tick half a cycle away from the clock edge. The only overlapping stimulus is the deliberate one-cycle overlap of a fixed expiry with a status clear.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int REG_W        = 32;
  localparam int CTL_PIT_AUTO = 22;
  localparam int CTL_FIT_IE   = 23;
  localparam int CTL_FIT_SEL  = 24;  // two bits: 25:24
  localparam int CTL_PIT_IE   = 26;
  localparam int STS_FIT      = 26;
  localparam int STS_PIT      = 27;

  function automatic int ivt_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/ivt_fit.sv
module ivt_fit #(
  parameter int E0 = 9,
  parameter int E1 = 13,
  parameter int E2 = 17,
  parameter int E3 = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  import ivt_pkg::*;

  localparam int CW      = ivt_max4(E0, E1, E2, E3);
  localparam int EXPS[4] = '{E0, E1, E2, E3};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] mask_tab [4];
  logic [CW-1:0] sel_mask;

  // one low-bit mask per selectable period
  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign mask_tab[g] = CW'((64'd1 << EXPS[g]) - 64'd1);
  end

  always_comb begin
    sel_mask = mask_tab[sel_i];
    expire_o = tick_i && ((cnt_q & sel_mask) == sel_mask);
    cnt_d    = cnt_q;
    if (tick_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FIT_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R2
endmodule

// File: rtl/ivt_pit.sv
module ivt_pit #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ie_i,
  input  logic          auto_i,
  input  logic          load_we_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  logic [CW-1:0] reload_q, reload_d;
  logic [CW-1:0] count_q, count_d;
  logic          run_q, run_d;

  always_comb begin
    reload_d = reload_q;
    count_d  = count_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (load_we_i) begin
      reload_d = load_val_i;
      count_d  = load_val_i;
      run_d    = ie_i && (load_val_i > CW'(1));
    end else if (!ie_i) begin
      run_d = 1'b0;
    end else if (run_q && tick_i) begin
      if (count_q == CW'(1)) begin
        expire_o = 1'b1;
        if (auto_i) begin
          count_d = reload_q;
        end else begin
          count_d = '0;
          run_d   = 1'b0;
        end
      end else begin
        count_d = count_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      run_q    <= run_d;
    end
  end

  assign count_o = count_q;

  AST_PIT_RUN_NEEDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (reload_q > CW'(1))); // R5
  AST_PIT_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && auto_i) |=> (count_q == $past(reload_q))); // R7
  AST_PIT_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !auto_i) |=> (!run_q && count_q == '0)); // R7
  AST_PIT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_we_i) |=> $stable(count_q)); // R8
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] clr_data_i,
  input  logic             fit_set_i,
  input  logic             pit_set_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] sts_o
);
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [REG_W-1:0] sts_q, sts_d;
  logic [REG_W-1:0] clr_mask, set_vec;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i) ctl_d = ctl_wdata_i;
    clr_mask = clr_we_i ? clr_data_i : '0;
    set_vec  = '0;
    set_vec[STS_FIT] = fit_set_i;
    set_vec[STS_PIT] = pit_set_i;
    // a set in the same cycle outranks a clear
    sts_d = (sts_q & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      sts_q <= sts_d;
    end
  end

  assign ctl_o = ctl_q;
  assign sts_o = sts_q;

  AST_STS_FIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fit_set_i |=> sts_o[STS_FIT]); // R2
  AST_STS_PIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pit_set_i |=> sts_o[STS_PIT]); // R6
  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_data_i[STS_FIT] && !fit_set_i) |=> !sts_o[STS_FIT]); // R4
endmodule

// File: rtl/ivt_pair.sv
module ivt_pair
  import ivt_pkg::*;
#(
  parameter int FIT_EXP0 = 9,
  parameter int FIT_EXP1 = 13,
  parameter int FIT_EXP2 = 17,
  parameter int FIT_EXP3 = 21,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             sts_clr_we_i,
  input  logic [REG_W-1:0] sts_clr_data_i,
  input  logic             pit_we_i,
  input  logic [CNT_W-1:0] pit_wdata_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] sts_o,
  output logic [CNT_W-1:0] pit_count_o,
  output logic             fit_irq_o,
  output logic             pit_irq_o
);
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_n_int;
  logic       fit_exp, pit_exp;

  // reset asserts at once, leaves after two clock edges
  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= rst_pipe_d;
  end
  assign rst_n_int = rst_pipe_q[1];

  ivt_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .clr_we_i   (sts_clr_we_i),
    .clr_data_i (sts_clr_data_i),
    .fit_set_i  (fit_exp),
    .pit_set_i  (pit_exp),
    .ctl_o      (ctl_o),
    .sts_o      (sts_o)
  );

  ivt_fit #(.E0(FIT_EXP0), .E1(FIT_EXP1), .E2(FIT_EXP2), .E3(FIT_EXP3)) i_fit (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick_i  (tick_i),
    .sel_i   (ctl_o[CTL_FIT_SEL+1:CTL_FIT_SEL]),
    .expire_o(fit_exp)
  );

  ivt_pit #(.CW(CNT_W)) i_pit (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_i    (tick_i),
    .ie_i      (ctl_o[CTL_PIT_IE]),
    .auto_i    (ctl_o[CTL_PIT_AUTO]),
    .load_we_i (pit_we_i),
    .load_val_i(pit_wdata_i),
    .count_o   (pit_count_o),
    .expire_o  (pit_exp)
  );

  assign fit_irq_o = sts_o[STS_FIT] & ctl_o[CTL_FIT_IE];
  assign pit_irq_o = sts_o[STS_PIT] & ctl_o[CTL_PIT_IE];
endmodule

// File: tb/test_ivt_pair.sv
module test_ivt_pair;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 10;

  // programmable-timer vectors: reload, auto, ticks, expected count, expected flag
  localparam logic [31:0] V_RELOAD [NV] = '{32'd5, 32'd5, 32'd5, 32'd5, 32'd5, 32'd4, 32'd1, 32'd0, 32'd2, 32'd3};
  localparam logic        V_AUTO   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          V_TICKS  [NV] = '{3, 5, 9, 5, 7, 12, 4, 3, 3, 2};
  localparam logic [31:0] V_COUNT  [NV] = '{32'd2, 32'd0, 32'd0, 32'd5, 32'd3, 32'd4, 32'd1, 32'd0, 32'd1, 32'd1};
  localparam logic        V_FLAG   [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n, tick, ctl_we, clr_we, pit_we;
  logic [31:0] ctl_wdata, clr_data, pit_wdata;
  logic [31:0] ctl_q, sts_q, pit_count;
  logic        fit_irq, pit_irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivt_pair #(.FIT_EXP0(3), .FIT_EXP1(4), .FIT_EXP2(5), .FIT_EXP3(6), .CNT_W(32)) i_ivt_pair (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .sts_clr_we_i(clr_we), .sts_clr_data_i(clr_data),
    .pit_we_i(pit_we), .pit_wdata_i(pit_wdata),
    .ctl_o(ctl_q), .sts_o(sts_q), .pit_count_o(pit_count),
    .fit_irq_o(fit_irq), .pit_irq_o(pit_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; ctl_we = 1'b0; clr_we = 1'b0; pit_we = 1'b0;
    ctl_wdata = '0; clr_data = '0; pit_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic wr_ctl(logic [31:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_clr(logic [31:0] v);
    clr_we = 1'b1; clr_data = v; @(negedge clk); clr_we = 1'b0;
  endtask

  task automatic wr_pit(logic [31:0] v);
    pit_we = 1'b1; pit_wdata = v; @(negedge clk); pit_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ctl", ctl_q, 32'h0);
    chk("R1 sts", sts_q, 32'h0);
    chk("R1 count", pit_count, 32'h0);
    chk("R1 irqs", {30'd0, fit_irq, pit_irq}, 32'h0);

    // R2 / R3: period 2^4 with the interrupt enabled
    wr_ctl((32'd1 << 24) | (32'd1 << 23));
    ticks(15);
    chk("R2 fit before period", {31'd0, sts_q[26]}, 32'd0);
    ticks(1);
    chk("R2 fit at period", {31'd0, sts_q[26]}, 32'd1);
    chk("R3 fit irq enabled", {31'd0, fit_irq}, 32'd1);
    wr_ctl(32'd1 << 24);
    chk("R3 fit irq masked", {31'd0, fit_irq}, 32'd0);
    chk("R3 flag kept", {31'd0, sts_q[26]}, 32'd1);

    // R4 write-one-to-clear
    wr_clr(32'd1 << 27);
    chk("R4 zero bit leaves flag", {31'd0, sts_q[26]}, 32'd1);
    wr_clr(32'd1 << 26);
    chk("R4 one bit clears flag", sts_q, 32'h0);

    // R2 repeats every period
    ticks(15);
    chk("R2 second period early", {31'd0, sts_q[26]}, 32'd0);
    ticks(1);
    chk("R2 second period", {31'd0, sts_q[26]}, 32'd1);

    // R2 longest selection, 2^6
    do_reset();
    wr_ctl(32'd3 << 24);
    ticks(63);
    chk("R2 sel3 early", {31'd0, sts_q[26]}, 32'd0);
    ticks(1);
    chk("R2 sel3 expiry", {31'd0, sts_q[26]}, 32'd1);

    // R4 set beats clear in the same cycle (sel0, 2^3)
    do_reset();
    ticks(7);
    tick = 1'b1; clr_we = 1'b1; clr_data = 32'd1 << 26;
    @(negedge clk);
    tick = 1'b0; clr_we = 1'b0;
    chk("R4 set wins over clear", {31'd0, sts_q[26]}, 32'd1);

    // R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      wr_clr(32'hFFFF_FFFF);
      wr_ctl((32'd1 << 26) | (32'(V_AUTO[i]) << 22));
      wr_pit(V_RELOAD[i]);
      ticks(V_TICKS[i]);
      chk($sformatf("R6 R7 vec%0d count", i), pit_count, V_COUNT[i]);
      chk($sformatf("R6 vec%0d flag", i), {31'd0, sts_q[27]}, {31'd0, V_FLAG[i]});
      chk($sformatf("R6 vec%0d irq", i), {31'd0, pit_irq}, {31'd0, V_FLAG[i]});
    end

    // R5 load without enable does not run
    wr_clr(32'hFFFF_FFFF);
    wr_ctl(32'd0);
    wr_pit(32'd6);
    ticks(8);
    chk("R5 disabled load holds", pit_count, 32'd6);
    chk("R5 disabled no flag", {31'd0, sts_q[27]}, 32'd0);

    // R8 no tick means no count; R5 clearing enable stops it
    wr_ctl((32'd1 << 26) | (32'd1 << 22));
    wr_pit(32'd10);
    repeat (5) @(negedge clk);
    chk("R8 idle holds", pit_count, 32'd10);
    ticks(3);
    chk("R6 counts ticks", pit_count, 32'd7);
    wr_ctl(32'd0);
    ticks(4);
    chk("R5 stopped by enable clear", pit_count, 32'd7);
    chk("R6 irq gated", {31'd0, pit_irq}, 32'd0);

    // R9 control read-back
    wr_ctl(32'hA5A5_0F0F);
    chk("R9 ctl readback", ctl_q, 32'hA5A5_0F0F);

    finish_run();
  end
endmodule